// File: doc/BRIEF.md
# PWM Channel Enable and Interrupt Controller

This block is the shared control section of a multi-channel pulse-width modulator. Software starts and stops channels, and masks or unmasks their interrupts, through pairs of write-one strobe registers. One register of the pair sets bits and the other clears them, so one channel can be changed without a read-modify-write of the others. Readback registers report which channels run and which interrupts are unmasked. The number of channels is a parameter, from 1 to 32, with 4 by default. Bit i of every register belongs to channel i.

Each channel's waveform logic pulses `period_end_i[i]` once at the end of each of its periods. Those pulses latch into a pending register whether or not the channel's interrupt is unmasked. Reading the pending register returns the latched bits and clears them in the same access. A single interrupt line is raised while any pending bit has its mask bit set. The per-channel waveform generators and the clock dividers sit outside this block.

The bus is a plain strobe interface. A write takes effect at the clock edge where `bus_wr_i` is high. A read captures its data at the edge where `bus_rd_i` is high, and `bus_rdata_o` holds that value from then until the next read.

Top module: `pwm_gc_top`

## Requirements
- R1: After reset, all channel enables, all interrupt mask bits and all pending bits are 0, so `chan_en_o` and `irq_o` are low.
- R2: A write to offset 0x04 sets each enable bit whose data bit is 1, and leaves the others unchanged. The new enables appear on `chan_en_o` after the write edge.
- R3: A write to offset 0x08 clears each enable bit whose data bit is 1, and leaves the others unchanged.
- R4: A read of offset 0x0C returns the enable state in bits [NCH-1:0], with the upper bits 0. The data is on `bus_rdata_o` from the read edge until the next read.
- R5: A write to offset 0x10 sets mask bits and a write to offset 0x14 clears mask bits, each acting only on the 1 bits of the data. A read of offset 0x18 returns the mask.
- R6: A high `period_end_i[i]` at a clock edge sets pending bit i whatever the mask holds. A read of offset 0x1C returns the pending bits and clears them.
- R7: A `period_end_i` pulse at the same edge as a read of 0x1C is not part of the returned value. It stays pending and is returned by the next read.
- R8: `irq_o` is high exactly while some channel has both its pending bit and its mask bit set. It is never high while the mask is all zero.
- R9: Writes to any offset other than 0x04, 0x08, 0x10 and 0x14 change no state. This includes writes to 0x0C, 0x18 and 0x1C. Reads of offsets other than 0x0C, 0x18 and 0x1C return 0.
- R10: Bit i of every register maps to channel i. Data bits at or above NCH are ignored on writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered at the read edge |
| period_end_i | input | NCH | Per-channel end-of-period pulses |
| chan_en_o | output | NCH | Per-channel run enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can meet in one cycle: a period-end pulse arriving, and a read of the pending register that clears it. The bench drives both on the same edge. In one case the pulse is for a channel not yet pending, and in another it is for a channel already pending. It expects the read to return only the bits latched earlier, and the following read to return the pulse bit. The mask-versus-pending sweep then covers all 256 combinations and checks `irq_o` before and after the clearing read.

// File: rtl/pwm_gc_pkg.sv
package pwm_gc_pkg;
  localparam int unsigned OFF_EN_SET   = 32'h04;
  localparam int unsigned OFF_EN_CLR   = 32'h08;
  localparam int unsigned OFF_EN_STAT  = 32'h0C;
  localparam int unsigned OFF_IM_SET   = 32'h10;
  localparam int unsigned OFF_IM_CLR   = 32'h14;
  localparam int unsigned OFF_IM_STAT  = 32'h18;
  localparam int unsigned OFF_IRQ_STAT = 32'h1C;

  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_SET,
    SEL_EN_CLR,
    SEL_EN_STAT,
    SEL_IM_SET,
    SEL_IM_CLR,
    SEL_IM_STAT,
    SEL_IRQ_STAT
  } reg_sel_e;
endpackage

// File: rtl/pwm_gc_decode.sv
module pwm_gc_decode
  import pwm_gc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (strobe_i) begin
      if      (addr_i == ADDR_W'(OFF_EN_SET))   sel_o = SEL_EN_SET;
      else if (addr_i == ADDR_W'(OFF_EN_CLR))   sel_o = SEL_EN_CLR;
      else if (addr_i == ADDR_W'(OFF_EN_STAT))  sel_o = SEL_EN_STAT;
      else if (addr_i == ADDR_W'(OFF_IM_SET))   sel_o = SEL_IM_SET;
      else if (addr_i == ADDR_W'(OFF_IM_CLR))   sel_o = SEL_IM_CLR;
      else if (addr_i == ADDR_W'(OFF_IM_STAT))  sel_o = SEL_IM_STAT;
      else if (addr_i == ADDR_W'(OFF_IRQ_STAT)) sel_o = SEL_IRQ_STAT;
    end
  end
endmodule

// File: rtl/pwm_gc_w1reg.sv
// Bit-vector register changed only through write-one set / write-one clear.
module pwm_gc_w1reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (set_i) q <= q | data_i;
    else if (clr_i) q <= q & ~data_i;
  end

  assign q_o = q;
endmodule

// File: rtl/pwm_gc_pend.sv
// Sticky event latch; an ack clears old bits but never drops a same-edge event.
module pwm_gc_pend #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         ack_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] kept;

  assign kept = ack_i ? '0 : q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= kept | evt_i;
  end

  assign q_o = q;
endmodule

// File: rtl/pwm_gc_top.sv
module pwm_gc_top
  import pwm_gc_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NCH-1:0]    period_end_i,
  output logic [NCH-1:0]    chan_en_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - NCH;

  reg_sel_e       wr_sel;
  reg_sel_e       rd_sel;
  logic [NCH-1:0] wr_bits;
  logic [NCH-1:0] chan_en;
  logic [NCH-1:0] irq_mask;
  logic [NCH-1:0] irq_pend;
  logic [NCH-1:0] rd_bits;
  logic [31:0]    rd_word;
  logic [31:0]    rdata_q;

  pwm_gc_decode #(.ADDR_W(ADDR_W)) u_wr_dec (
    .strobe_i (bus_wr_i),
    .addr_i   (bus_addr_i),
    .sel_o    (wr_sel)
  );

  pwm_gc_decode #(.ADDR_W(ADDR_W)) u_rd_dec (
    .strobe_i (bus_rd_i),
    .addr_i   (bus_addr_i),
    .sel_o    (rd_sel)
  );

  assign wr_bits = bus_wdata_i[NCH-1:0];

  generate
    if (NCH < DATA_W) begin : g_pad
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:NCH];
      assign rd_word = {{PAD_W{1'b0}}, rd_bits};
    end else begin : g_full
      assign rd_word = rd_bits;
    end
  endgenerate

  pwm_gc_w1reg #(.W(NCH)) u_chan_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr_sel == SEL_EN_SET),
    .clr_i  (wr_sel == SEL_EN_CLR),
    .data_i (wr_bits),
    .q_o    (chan_en)
  );

  pwm_gc_w1reg #(.W(NCH)) u_irq_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr_sel == SEL_IM_SET),
    .clr_i  (wr_sel == SEL_IM_CLR),
    .data_i (wr_bits),
    .q_o    (irq_mask)
  );

  pwm_gc_pend #(.W(NCH)) u_irq_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (period_end_i),
    .ack_i  (rd_sel == SEL_IRQ_STAT),
    .q_o    (irq_pend)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_EN_STAT:  rd_bits = chan_en;
      SEL_IM_STAT:  rd_bits = irq_mask;
      SEL_IRQ_STAT: rd_bits = irq_pend;
      default:      rd_bits = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_word;
  end

  assign bus_rdata_o = rdata_q;
  assign chan_en_o   = chan_en;
  assign irq_o       = |(irq_pend & irq_mask);
endmodule

// File: rtl/pwm_gc_checker.sv
module pwm_gc_checker
  import pwm_gc_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic [NCH-1:0]    period_end_i,
  input logic [NCH-1:0]    chan_en_o,
  input logic              irq_o,
  input logic [NCH-1:0]    mask_i,
  input logic [NCH-1:0]    pend_i
);
  logic wr_ena, wr_dis, rd_en_stat, rd_pend;
  assign wr_ena     = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_EN_SET));
  assign wr_dis     = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_EN_CLR));
  assign rd_en_stat = bus_rd_i && (bus_addr_i == ADDR_W'(OFF_EN_STAT));
  assign rd_pend    = bus_rd_i && (bus_addr_i == ADDR_W'(OFF_IRQ_STAT));

  assert_ena_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ena |=> (chan_en_o & $past(bus_wdata_i[NCH-1:0])) == $past(bus_wdata_i[NCH-1:0]));

  assert_ena_zero_keeps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ena |=> (chan_en_o & ~$past(bus_wdata_i[NCH-1:0])) ==
               ($past(chan_en_o) & ~$past(bus_wdata_i[NCH-1:0])));

  assert_dis_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dis |=> (chan_en_o & $past(bus_wdata_i[NCH-1:0])) == '0);

  assert_en_readback_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_stat |=> bus_rdata_o[NCH-1:0] == $past(chan_en_o));

  assert_pend_readback_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend |=> bus_rdata_o[NCH-1:0] == $past(pend_i));

  assert_evt_latched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_end_i != '0) |=> (pend_i & $past(period_end_i)) == $past(period_end_i));

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend |=> pend_i == $past(period_end_i));

  assert_irq_needs_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);

  assert_en_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ena || wr_dis) |=> $stable(chan_en_o));
endmodule

bind pwm_gc_top pwm_gc_checker #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_wr_i     (bus_wr_i),
  .bus_rd_i     (bus_rd_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .period_end_i (period_end_i),
  .chan_en_o    (chan_en_o),
  .irq_o        (irq_o),
  .mask_i       (irq_mask),
  .pend_i       (irq_pend)
);

// File: tb/pwm_gc_top_test.sv
`timescale 1ns/1ps
module pwm_gc_top_test;
  localparam int NCH    = 4;
  localparam int ADDR_W = 8;
  localparam logic [7:0] A_EN_SET = 8'h04, A_EN_CLR = 8'h08, A_EN_STAT = 8'h0C;
  localparam logic [7:0] A_IM_SET = 8'h10, A_IM_CLR = 8'h14, A_IM_STAT = 8'h18;
  localparam logic [7:0] A_PEND   = 8'h1C;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              wr = 0, rd = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCH-1:0]    evt = '0;
  logic [NCH-1:0]    chan_en;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_gc_top #(.NCH(NCH), .ADDR_W(ADDR_W)) uut (
    .clk_i (clk), .rst_ni (rst_n),
    .bus_wr_i (wr), .bus_rd_i (rd), .bus_addr_i (addr),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata),
    .period_end_i (evt), .chan_en_o (chan_en), .irq_o (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; one rising edge in between.
  task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                     input logic [31:0] d, input logic [NCH-1:0] e);
    wr = w; rd = r; addr = a; wdata = d; evt = e;
    @(posedge clk);
    @(negedge clk);
    wr = 0; rd = 0; wdata = '0; evt = '0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b0, a, d, '0);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
    cyc(1'b0, 1'b1, a, '0, '0);
    v = rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] e);
    cyc(1'b0, 1'b0, '0, '0, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    @(negedge clk);
    @(negedge clk);
    check("R1 chan_en in reset", 32'(chan_en), 0);
    check("R1 irq in reset", 32'(irq), 0);
    rst_n = 1;
    @(negedge clk);
    rd_reg(A_EN_STAT, v); check("R1 enable readback", v, 0);
    rd_reg(A_IM_STAT, v); check("R1 mask readback", v, 0);
    rd_reg(A_PEND, v);    check("R1 pending readback", v, 0);

    // R2/R4: set sweep over every start state and write pattern
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 16; p++) begin
        wr_reg(A_EN_CLR, 32'hF);
        wr_reg(A_EN_SET, 32'(s));
        wr_reg(A_EN_SET, 32'(p));
        check("R2 set", 32'(chan_en), 32'(s | p));
        rd_reg(A_EN_STAT, v);
        check("R4 enable readback", v, 32'(s | p));
      end
    end

    // R3: clear sweep
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 16; p++) begin
        wr_reg(A_EN_CLR, 32'hF);
        wr_reg(A_EN_SET, 32'(s));
        wr_reg(A_EN_CLR, 32'(p));
        check("R3 clear", 32'(chan_en), 32'(s & ~p & 4'hF));
      end
    end

    // R5: mask set and clear sweep
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 16; p++) begin
        wr_reg(A_IM_CLR, 32'hF);
        wr_reg(A_IM_SET, 32'(s));
        rd_reg(A_IM_STAT, v);
        check("R5 mask set", v, 32'(s));
        wr_reg(A_IM_CLR, 32'(p));
        rd_reg(A_IM_STAT, v);
        check("R5 mask clear", v, 32'(s & ~p & 4'hF));
      end
    end

    // R6/R8: pending versus mask, all combinations
    for (int m = 0; m < 16; m++) begin
      for (int e = 0; e < 16; e++) begin
        wr_reg(A_IM_CLR, 32'hF);
        wr_reg(A_IM_SET, 32'(m));
        rd_reg(A_PEND, v);
        pulse(4'(e));
        check("R8 irq raised", 32'(irq), 32'((m & e) != 0));
        rd_reg(A_PEND, v);
        check("R6 pending read", v, 32'(e));
        check("R8 irq after clear", 32'(irq), 0);
        rd_reg(A_PEND, v);
        check("R6 pending cleared", v, 0);
      end
    end
    wr_reg(A_IM_CLR, 32'hF);

    // R10: per-channel bit position and upper bits
    for (int i = 0; i < NCH; i++) begin
      pulse(4'(1 << i));
      rd_reg(A_PEND, v);
      check("R10 channel bit", v, 32'(1 << i));
    end
    wr_reg(A_EN_SET, 32'hFFFF_FFFF);
    rd_reg(A_EN_STAT, v);
    check("R10 upper bits zero", v, 32'h0000_000F);
    wr_reg(A_EN_CLR, 32'hFFFF_FFF0);
    check("R10 upper clear bits ignored", 32'(chan_en), 32'hF);

    // R7: event at the same edge as the clearing read
    pulse(4'b0011);
    cyc(1'b0, 1'b1, A_PEND, '0, 4'b0100);
    check("R7 read excludes same-edge event", rdata, 32'h3);
    rd_reg(A_PEND, v);
    check("R7 same-edge event kept", v, 32'h4);
    pulse(4'b0001);
    cyc(1'b0, 1'b1, A_PEND, '0, 4'b0001);
    check("R7 already-pending bit read", rdata, 32'h1);
    rd_reg(A_PEND, v);
    check("R7 re-pended bit kept", v, 32'h1);

    // R9: writes to other offsets, reads of write-only offsets
    wr_reg(A_EN_CLR, 32'hF); wr_reg(A_EN_SET, 32'h5);
    wr_reg(A_IM_CLR, 32'hF); wr_reg(A_IM_SET, 32'hA);
    pulse(4'b0110);
    wr_reg(8'h00, 32'hFFFF_FFFF);
    wr_reg(A_EN_STAT, 32'hFFFF_FFFF);
    wr_reg(A_IM_STAT, 32'hFFFF_FFFF);
    wr_reg(A_PEND, 32'hFFFF_FFFF);
    wr_reg(8'h20, 32'hFFFF_FFFF);
    wr_reg(8'h05, 32'hFFFF_FFFF);
    check("R9 enables unchanged", 32'(chan_en), 32'h5);
    rd_reg(A_IM_STAT, v); check("R9 mask unchanged", v, 32'hA);
    check("R9 irq with pending 6 mask A", 32'(irq), 1);
    foreach (A_LIST[k]) begin
      rd_reg(A_LIST[k], v); check("R9 write-only offset reads 0", v, 0);
    end
    rd_reg(A_PEND, v); check("R9 pending unchanged", v, 32'h6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [7:0] A_LIST [6] = '{8'h00, A_EN_SET, A_EN_CLR, A_IM_SET, A_IM_CLR, 8'h20};
endmodule